// File: doc/BRIEF.md
# SPI Radio-Controller Transaction Engine

This block is the host side of a status-gated SPI link to an external radio controller. A request is either a write, which sends a packet of `req_len` bytes (command header and payload together) that is pulled one byte at a time from a byte stream, or a read, which drains the bytes the controller has queued into a local receive FIFO. Every transfer opens with a five-byte status exchange. The host sends an access byte and four zero bytes. The controller answers with a readiness byte and two little-endian 16-bit counts: the space it has free, then the bytes it has pending.

A not-ready answer makes the engine raise chip select, hold it high for a guard interval, lower it again and repeat the exchange. It does this up to a programmable number of times. A write is refused unless the advertised free space covers the whole packet. A read is only attempted while the controller's data-ready input is high. It stops when the pending count runs out or when the FIFO fills, whichever comes first. Each request finishes with a one-cycle `done` pulse and a result code. The SPI shifter itself is outside the block: a byte-level start/done port stands in for it.

The controlling state machine has ten states:
- IDLE waits for a request.
- HDR_XFER starts one status byte.
- HDR_WAIT collects the reply to that byte.
- EVAL judges the reply.
- GAP holds chip select high between retries.
- WR_XFER and WR_WAIT move packet bytes.
- RD_XFER and RD_WAIT move filler bytes out and received bytes in.
- FINISH reports the result.

Transitions:
- IDLE goes to HDR_XFER on an accepted request, or straight to FINISH on a read with data-ready low.
- HDR_XFER goes to HDR_WAIT.
- HDR_WAIT returns to HDR_XFER after each reply until the fifth, then goes to EVAL.
- EVAL goes to GAP on a not-ready reply with retries left, or to FINISH once they are used up.
- EVAL goes to FINISH on a write that lacks space, to WR_XFER on a write that fits, and to RD_XFER on a read.
- GAP goes to HDR_XFER once the guard time has expired.
- WR_XFER goes to WR_WAIT, or to FINISH when the packet is complete.
- RD_XFER goes to RD_WAIT, or to FINISH when the count is exhausted or the FIFO is full.
- WR_WAIT and RD_WAIT return to their XFER state on the byte-done strobe.
- FINISH goes to IDLE.

Top module: `spi_link_engine`

## Requirements
- R1: After reset, `cs_n` is high, `busy`, `done`, `spi_start` and `rxq_valid` are low.
- R2: Every status exchange sends, with `cs_n` low on each byte, the access byte 0x0A for a write or 0x0B for a read, followed by four 0x00 bytes.
- R3: A first reply byte other than 0x02 means not ready. The engine raises `cs_n`, keeps it high for at least `CS_GAP` cycles, lowers it and repeats the five-byte exchange.
- R4: If the reply is still not ready after `retry_limit` retries, the request ends with result ERROR (2) and `cs_n` high, and no packet or filler byte is sent.
- R5: Reply bytes 1 (low) and 2 (high) form the free-space count. A write whose `req_len` exceeds it ends with result WOULD_BLOCK (1) after the status bytes only, with `cs_n` released.
- R6: A permitted write sends exactly `req_len` bytes from the stream, in stream order, straight after the status bytes. It then releases `cs_n` and ends with result OK (0).
- R7: A read requested while `data_ready` is low ends with WOULD_BLOCK (1). No SPI byte is started and `cs_n` never goes low.
- R8: Reply bytes 3 (low) and 4 (high) form the pending count. A read clocks out 0x00 filler bytes and stores each received byte in the FIFO in arrival order, up to that count (none when it is zero), then ends with OK (0).
- R9: A read stops with OK as soon as the FIFO holds `FIFO_DEPTH` bytes, even if the pending count is larger. The FIFO never overflows.
- R10: `busy` is high from the cycle after a request is accepted until the `done` cycle. `done` is a single-cycle pulse, and `result` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_len | input | 16 | Total packet length in bytes for a write |
| retry_limit | input | RETRY_W | Maximum number of not-ready retries |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 OK, 1 WOULD_BLOCK, 2 ERROR |
| wr_byte | input | 8 | Current byte of the outgoing packet stream |
| wr_take | output | 1 | Consumes `wr_byte` |
| data_ready | input | 1 | Controller has data pending |
| cs_n | output | 1 | Chip select, active low |
| spi_start | output | 1 | Start one SPI byte transfer |
| spi_tx | output | 8 | Byte to shift out |
| spi_rx | input | 8 | Byte shifted in, valid with `spi_done` |
| spi_done | input | 1 | Byte transfer complete |
| rxq_data | output | 8 | Receive FIFO head byte |
| rxq_valid | output | 1 | Receive FIFO not empty |
| rxq_pop | input | 1 | Remove the head byte |

## Verification
The bench builds the engine with `FIFO_DEPTH` = 4 and `CS_GAP` = 3, and drives `retry_limit` at 2. The shallow FIFO makes the full-FIFO cut-off occur on a read whose advertised count is 262. That count also needs both bytes of the little-endian field. The short guard interval and small retry limit let the retry loop and the ERROR exit run in a few dozen cycles, and the bench measures the chip-select high time between attempts. A write whose free-space count is 0x0100 tests that the high byte of the field is honoured, and a write whose free space exactly equals its length tests the acceptance boundary.

// File: rtl/spi_link_pkg.sv
package spi_link_pkg;

    localparam int          HDR_BYTES   = 5;
    localparam int          CNT_W       = 16;
    localparam logic [7:0]  ACC_WRITE   = 8'h0A;
    localparam logic [7:0]  ACC_READ    = 8'h0B;
    localparam logic [7:0]  REPLY_READY = 8'h02;

    typedef enum logic [1:0] {
        RES_OK          = 2'd0,
        RES_WOULD_BLOCK = 2'd1,
        RES_ERROR       = 2'd2
    } link_res_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_HDR_XFER,
        S_HDR_WAIT,
        S_EVAL,
        S_GAP,
        S_WR_XFER,
        S_WR_WAIT,
        S_RD_XFER,
        S_RD_WAIT,
        S_FINISH
    } link_state_e;

endpackage

// File: rtl/link_hdr_capture.sv
module link_hdr_capture
    import spi_link_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [2:0]       cap_idx,
    input  logic [7:0]       cap_byte,
    output logic             ready_ok,
    output logic [CNT_W-1:0] accept_cnt,
    output logic [CNT_W-1:0] avail_cnt
);

    logic [7:0] hb [HDR_BYTES];

    for (genvar g = 0; g < HDR_BYTES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hb[g] <= 8'h00;
            end else if (cap_en && cap_idx == 3'(g)) begin
                hb[g] <= cap_byte;
            end
        end
    end

    assign ready_ok   = (hb[0] == REPLY_READY);
    assign accept_cnt = {hb[2], hb[1]};
    assign avail_cnt  = {hb[4], hb[3]};

    // R2: only the five status slots are ever captured
    p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> (cap_idx < 3'(HDR_BYTES)));

endmodule

// File: rtl/link_gap_timer.sv
module link_gap_timer #(
    parameter int GAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    localparam int CW = $clog2(GAP + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(GAP);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R3: a load always yields a non-expired interval in the next cycle
    p_load_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !expired);

endmodule

// File: rtl/link_rx_fifo.sv
module link_rx_fifo #(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] push_data,
    input  logic       pop,
    output logic [7:0] head,
    output logic       valid,
    output logic       full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && !full;
    assign do_pop  = pop && valid;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head  = mem[rp];
    assign valid = (cnt != '0);
    assign full  = (cnt == CW'(DEPTH));

    // R9: the engine never pushes into a full FIFO
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R9: occupancy stays within depth
    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

endmodule

// File: rtl/spi_link_engine.sv
module spi_link_engine
    import spi_link_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int CS_GAP     = 4,
    parameter int RETRY_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [15:0]        req_len,
    input  logic [RETRY_W-1:0] retry_limit,
    output logic               busy,
    output logic               done,
    output logic [1:0]         result,
    input  logic [7:0]         wr_byte,
    output logic               wr_take,
    input  logic               data_ready,
    output logic               cs_n,
    output logic               spi_start,
    output logic [7:0]         spi_tx,
    input  logic [7:0]         spi_rx,
    input  logic               spi_done,
    output logic [7:0]         rxq_data,
    output logic               rxq_valid,
    input  logic               rxq_pop
);

    localparam int HW = $clog2(CS_GAP + 2);

    link_state_e        state, nstate;
    logic               is_write;
    logic [CNT_W-1:0]   len_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [2:0]         hdr_idx;
    logic [RETRY_W-1:0] retries;
    logic               cs_n_q;
    link_res_e          res_q;

    logic               hdr_ready;
    logic [CNT_W-1:0]   hdr_accept, hdr_avail;
    logic               cap_en, gap_load, gap_expired;
    logic               fifo_push, fifo_full;
    logic               wr_end, rd_end, retry_out, no_space, rd_blocked;

    assign wr_end     = (cnt_q == len_q);
    assign rd_end     = (cnt_q == '0) || fifo_full;
    assign retry_out  = (retries == retry_limit);
    assign no_space   = (hdr_accept < len_q);
    assign rd_blocked = !req_write && !data_ready;

    link_hdr_capture u_hdr (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (cap_en),
        .cap_idx    (hdr_idx),
        .cap_byte   (spi_rx),
        .ready_ok   (hdr_ready),
        .accept_cnt (hdr_accept),
        .avail_cnt  (hdr_avail)
    );

    link_gap_timer #(.GAP(CS_GAP)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .expired (gap_expired)
    );

    link_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (spi_rx),
        .pop       (rxq_pop),
        .head      (rxq_data),
        .valid     (rxq_valid),
        .full      (fifo_full)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:     if (req_valid) nstate = rd_blocked ? S_FINISH : S_HDR_XFER;
            S_HDR_XFER: nstate = S_HDR_WAIT;
            S_HDR_WAIT: if (spi_done) nstate = (hdr_idx == 3'(HDR_BYTES - 1)) ? S_EVAL : S_HDR_XFER;
            S_EVAL: begin
                if (!hdr_ready)    nstate = retry_out ? S_FINISH : S_GAP;
                else if (is_write) nstate = no_space ? S_FINISH : S_WR_XFER;
                else               nstate = S_RD_XFER;
            end
            S_GAP:      if (gap_expired) nstate = S_HDR_XFER;
            S_WR_XFER:  nstate = wr_end ? S_FINISH : S_WR_WAIT;
            S_WR_WAIT:  if (spi_done) nstate = S_WR_XFER;
            S_RD_XFER:  nstate = rd_end ? S_FINISH : S_RD_WAIT;
            S_RD_WAIT:  if (spi_done) nstate = S_RD_XFER;
            S_FINISH:   nstate = S_IDLE;
            default:    nstate = S_IDLE;
        endcase
    end

    // Outputs and strobes
    always_comb begin
        spi_start = 1'b0;
        spi_tx    = 8'h00;
        wr_take   = 1'b0;
        cap_en    = 1'b0;
        gap_load  = 1'b0;
        fifo_push = 1'b0;
        unique case (state)
            S_HDR_XFER: begin
                spi_start = 1'b1;
                if (hdr_idx == 3'd0) spi_tx = is_write ? ACC_WRITE : ACC_READ;
            end
            S_HDR_WAIT: cap_en   = spi_done;
            S_EVAL:     gap_load = !hdr_ready && !retry_out;
            S_WR_XFER: begin
                spi_start = !wr_end;
                wr_take   = !wr_end;
                spi_tx    = wr_byte;
            end
            S_RD_XFER:  spi_start = !rd_end;
            S_RD_WAIT:  fifo_push = spi_done;
            default: ;
        endcase
    end

    assign busy   = (state != S_IDLE);
    assign done   = (state == S_FINISH);
    assign result = res_q;
    assign cs_n   = cs_n_q;

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_write <= 1'b0;
            len_q    <= '0;
            cnt_q    <= '0;
            hdr_idx  <= '0;
            retries  <= '0;
            cs_n_q   <= 1'b1;
            res_q    <= RES_OK;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    is_write <= req_write;
                    len_q    <= req_len;
                    retries  <= '0;
                    hdr_idx  <= '0;
                    res_q    <= RES_OK;
                    if (rd_blocked) res_q  <= RES_WOULD_BLOCK;
                    else            cs_n_q <= 1'b0;
                end
                S_HDR_WAIT: if (spi_done && hdr_idx != 3'(HDR_BYTES - 1)) begin
                    hdr_idx <= hdr_idx + 1'b1;
                end
                S_EVAL: begin
                    if (!hdr_ready) begin
                        cs_n_q  <= 1'b1;
                        hdr_idx <= '0;
                        if (retry_out) res_q   <= RES_ERROR;
                        else           retries <= retries + 1'b1;
                    end else if (is_write) begin
                        cnt_q <= '0;
                        if (no_space) begin
                            cs_n_q <= 1'b1;
                            res_q  <= RES_WOULD_BLOCK;
                        end
                    end else begin
                        cnt_q <= hdr_avail;
                    end
                end
                S_GAP:     if (gap_expired) cs_n_q <= 1'b0;
                S_WR_XFER: if (wr_end) cs_n_q <= 1'b1;
                S_WR_WAIT: if (spi_done) cnt_q <= cnt_q + 1'b1;
                S_RD_XFER: if (rd_end) cs_n_q <= 1'b1;
                S_RD_WAIT: if (spi_done) cnt_q <= cnt_q - 1'b1;
                S_FINISH:  cs_n_q <= 1'b1;
                default: ;
            endcase
        end
    end

    // Chip-select high-time tracker for the guard-interval check
    logic [HW-1:0] hi_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           hi_cnt <= '0;
        else if (!cs_n_q)                     hi_cnt <= '0;
        else if (hi_cnt != HW'(CS_GAP))       hi_cnt <= hi_cnt + 1'b1;
    end

    // R2: every SPI byte is framed by an asserted chip select
    p_cs_framed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_start |-> !cs_n);

    // R2: a start is never repeated before its completion wait
    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_start |=> !spi_start);

    // R3: reassertion after a retry honours the guard interval
    p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && $past(state) == S_GAP) |-> (hi_cnt >= HW'(CS_GAP)));

    // R5: packet bytes flow only when the advertised space suffices
    p_space_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |-> (hdr_accept >= len_q));

    // R7: a blocked read never touches chip select
    p_wb_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && req_valid && rd_blocked)
        |=> (cs_n && done && result == 2'(RES_WOULD_BLOCK)));

    // R10: done lasts one cycle and releases chip select
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cs_n));

endmodule

// File: tb/spi_link_engine_bench.sv
module spi_link_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int GAP        = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_len = '0;
    logic [7:0]  retry_limit = 8'd2;
    logic        busy, done, wr_take, cs_n, spi_start, rxq_valid;
    logic [1:0]  result;
    logic [7:0]  wr_byte, spi_tx, rxq_data;
    logic        data_ready = 1'b1;
    logic [7:0]  spi_rx = 8'h00;
    logic        spi_done = 1'b0;
    logic        rxq_pop = 1'b0;

    logic [7:0]  wr_mem [16];
    logic [3:0]  wr_idx = '0;
    assign wr_byte = wr_mem[wr_idx];

    int n_checks = 0, n_errors = 0;
    int starts_seen = 0, min_gap = 1000, hi_run = 0;
    bit cs_low_seen = 0, prev_cs = 1, finished = 0;
    string cur_tag = "R2";
    logic [7:0] exp_tx [$];
    logic [7:0] reply_q [$];
    logic [7:0] exp_rx [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_link_engine #(.FIFO_DEPTH(DEPTH), .CS_GAP(GAP), .RETRY_W(8)) u_spi_link_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_len(req_len), .retry_limit(retry_limit), .busy(busy), .done(done),
        .result(result), .wr_byte(wr_byte), .wr_take(wr_take), .data_ready(data_ready),
        .cs_n(cs_n), .spi_start(spi_start), .spi_tx(spi_tx), .spi_rx(spi_rx),
        .spi_done(spi_done), .rxq_data(rxq_data), .rxq_valid(rxq_valid), .rxq_pop(rxq_pop)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver side: queue expected status bytes and the controller's reply
    task automatic exp_hdr(input logic [7:0] acc, input logic [7:0] r0,
                           input logic [15:0] space, input logic [15:0] pend);
        exp_tx.push_back(acc);
        repeat (4) exp_tx.push_back(8'h00);
        reply_q.push_back(r0);
        reply_q.push_back(space[7:0]);
        reply_q.push_back(space[15:8]);
        reply_q.push_back(pend[7:0]);
        reply_q.push_back(pend[15:8]);
    endtask

    // Monitor: controller model and scoreboard of outgoing bytes
    initial begin : monitor
        bit         pend;
        logic [7:0] pend_rx;
        pend = 0;
        pend_rx = 8'h00;
        forever begin
            @(posedge clk); #1;
            spi_done = 1'b0;
            if (cs_n) hi_run++;
            else begin
                if (prev_cs && cs_low_seen && hi_run < min_gap) min_gap = hi_run;
                hi_run = 0;
                cs_low_seen = 1;
            end
            prev_cs = cs_n;
            if (spi_start) begin
                starts_seen++;
                chk(cs_n == 1'b0, "R2 cs low on byte", cs_n, 0);
                if (exp_tx.size() == 0) chk(0, {cur_tag, " unexpected byte"}, spi_tx, 0);
                else begin
                    logic [7:0] e;
                    e = exp_tx.pop_front();
                    chk(spi_tx == e, {cur_tag, " tx byte"}, spi_tx, e);
                end
                if (wr_take) wr_idx = wr_idx + 1'b1;
                pend = 1;
                pend_rx = (reply_q.size() != 0) ? reply_q.pop_front() : 8'h5A;
            end else if (pend) begin
                spi_rx = pend_rx;
                spi_done = 1'b1;
                pend = 0;
            end
        end
    end

    task automatic do_req(input bit wr, input int len, input logic [1:0] exp_res, input string tag);
        int t;
        cur_tag = tag;
        wr_idx = '0;
        cs_low_seen = 0;
        min_gap = 1000;
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_len = 16'(len);
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk(busy == 1'b1, "R10 busy after accept", busy, 1);
        t = 0;
        while (!done && t < 3000) begin @(posedge clk); #1; t++; end
        chk(done == 1'b1, {tag, " done seen"}, done, 1);
        chk(result == exp_res, {tag, " result"}, result, exp_res);
        @(posedge clk); #1;
        chk(!done && !busy, "R10 done single pulse", {done, busy}, 0);
        chk(cs_n == 1'b1, {tag, " cs released"}, cs_n, 1);
        chk(exp_tx.size() == 0, {tag, " all bytes sent"}, exp_tx.size(), 0);
        reply_q.delete();
    endtask

    task automatic drain(input string tag);
        while (exp_rx.size() != 0) begin
            logic [7:0] e;
            e = exp_rx.pop_front();
            chk(rxq_valid == 1'b1, {tag, " fifo valid"}, rxq_valid, 1);
            chk(rxq_data == e, {tag, " fifo byte"}, rxq_data, e);
            rxq_pop = 1'b1;
            @(posedge clk); #1;
            rxq_pop = 1'b0;
        end
        chk(rxq_valid == 1'b0, {tag, " fifo empty"}, rxq_valid, 0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
        chk(!spi_start && !rxq_valid, "R1 start/valid", {spi_start, rxq_valid}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(cs_n == 1'b1 && !busy, "R1 idle after reset", {cs_n, busy}, 2);

        // R6 permitted write of three bytes
        wr_mem[0] = 8'hA1; wr_mem[1] = 8'hB2; wr_mem[2] = 8'hC3;
        exp_hdr(8'h0A, 8'h02, 16'd16, 16'd0);
        exp_tx.push_back(8'hA1); exp_tx.push_back(8'hB2); exp_tx.push_back(8'hC3);
        do_req(1, 3, 2'd0, "R6");

        // R5 refused write: space 2 < length 3
        exp_hdr(8'h0A, 8'h02, 16'd2, 16'd0);
        do_req(1, 3, 2'd1, "R5");

        // R5 boundary: space equals length
        wr_mem[0] = 8'h10; wr_mem[1] = 8'h20; wr_mem[2] = 8'h30; wr_mem[3] = 8'h40;
        exp_hdr(8'h0A, 8'h02, 16'd4, 16'd0);
        for (int i = 0; i < 4; i++) exp_tx.push_back(wr_mem[i]);
        do_req(1, 4, 2'd0, "R5");

        // R5 little-endian space: 0x0100 covers six bytes
        for (int i = 0; i < 6; i++) wr_mem[i] = 8'(8'h60 + i);
        exp_hdr(8'h0A, 8'h02, 16'h0100, 16'd0);
        for (int i = 0; i < 6; i++) exp_tx.push_back(8'(8'h60 + i));
        do_req(1, 6, 2'd0, "R5");

        // R3 one not-ready reply, then ready
        wr_mem[0] = 8'hE1; wr_mem[1] = 8'hE2;
        exp_hdr(8'h0A, 8'h00, 16'd0, 16'd0);
        exp_hdr(8'h0A, 8'h02, 16'd8, 16'd0);
        exp_tx.push_back(8'hE1); exp_tx.push_back(8'hE2);
        do_req(1, 2, 2'd0, "R3");
        chk(min_gap >= GAP && min_gap < 1000, "R3 cs high gap", min_gap, GAP);

        // R4 never ready with a limit of two retries
        exp_hdr(8'h0B, 8'h07, 16'd0, 16'd5);
        exp_hdr(8'h0B, 8'hFF, 16'd0, 16'd5);
        exp_hdr(8'h0B, 8'h00, 16'd0, 16'd5);
        do_req(0, 0, 2'd2, "R4");
        chk(rxq_valid == 1'b0, "R4 nothing read", rxq_valid, 0);

        // R7 read with data-ready low
        data_ready = 1'b0;
        starts_seen = 0;
        do_req(0, 0, 2'd1, "R7");
        chk(starts_seen == 0, "R7 no spi byte", starts_seen, 0);
        chk(cs_low_seen == 0, "R7 cs stayed high", cs_low_seen, 0);
        data_ready = 1'b1;

        // R8 read of three pending bytes
        exp_hdr(8'h0B, 8'h02, 16'd0, 16'd3);
        repeat (3) exp_tx.push_back(8'h00);
        reply_q.push_back(8'h11); reply_q.push_back(8'h22); reply_q.push_back(8'h33);
        exp_rx.push_back(8'h11); exp_rx.push_back(8'h22); exp_rx.push_back(8'h33);
        do_req(0, 0, 2'd0, "R8");
        drain("R8");

        // R8 pending count zero
        exp_hdr(8'h0B, 8'h02, 16'd0, 16'd0);
        do_req(0, 0, 2'd0, "R8");
        chk(rxq_valid == 1'b0, "R8 empty read", rxq_valid, 0);

        // R9 pending 0x0106 stops at the FIFO depth
        exp_hdr(8'h0B, 8'h02, 16'd0, 16'h0106);
        for (int i = 0; i < DEPTH; i++) begin
            exp_tx.push_back(8'h00);
            reply_q.push_back(8'(8'hC0 + i));
            exp_rx.push_back(8'(8'hC0 + i));
        end
        do_req(0, 0, 2'd0, "R9");
        drain("R9");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule